// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller. It serves up to three banks of 32 pins each. For every pin it holds an output latch and a direction bit, and it samples the pin input through a two-flop synchronizer. Software changes output bits only through dedicated set and clear words. A write to either word touches only the bits written as 1, so concurrent agents never need a read-modify-write sequence on the output latch.

Each pin can capture rising edges, falling edges, or both. A captured edge lands in a sticky per-pin status bit, which stays set until software writes 1 to it. A per-bank gate word decides which pins may capture at all. The controller drives one combined interrupt line that covers every bank. It also drives two dedicated lines that follow pins 0 and 1 of bank 0, so their handlers can skip the demultiplexing step.

Every register is one 32-bit word, and pin p maps to bit p mod 32 of its bank's words. The banks interleave: bank n's copy of a register sits 4 bytes above bank n-1's copy.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the direction, output latch, rising enable, falling enable, edge status and edge gate words of every bank are zero. All pin outputs, output enables and interrupt lines are low.
- R2: A write to the set word (byte offset 0x18 + 4*bank) drives high every output bit written as 1. Output bits written as 0 keep their value.
- R3: A write to the clear word (byte offset 0x24 + 4*bank) drives low every output bit written as 1. Output bits written as 0 keep their value.
- R4: The direction word (byte offset 0x0C + 4*bank) can be written and read back. A 1 in bit p enables the output driver of that pin, and a 0 makes the pin an input.
- R5: A read of the level word (byte offset 0x00 + 4*bank) returns the synchronized pin inputs. A pin change becomes visible two clock edges after it is applied.
- R6: A pin with its bit set in the rising-enable word (byte offset 0x30 + 4*bank) and in the edge gate word sets its status bit on a 0-to-1 transition of its synchronized input.
- R7: A pin with its bit set in the falling-enable word (byte offset 0x3C + 4*bank) and in the edge gate word sets its status bit on a 1-to-0 transition. A transition in a direction that is not enabled leaves the status bit unchanged.
- R8: The status word (byte offset 0x48 + 4*bank) reads back the captured edges. Writing 1 to a bit clears it, and bits written as 0 stay as they are.
- R9: The edge gate word (byte offset 0x9C + 4*bank) must have a pin's bit at 1 for that pin to capture edges. An enabled edge on a pin whose gate bit is 0 does not set its status bit.
- R10: The combined interrupt is high whenever any bank has a status bit set whose gate bit is also set. The two dedicated interrupts follow the gated status bits of pins 0 and 1 in bank 0.
- R11: When a new enabled edge and a write-1-to-clear reach the same status bit in the same cycle, the bit stays set.
- R12: A read returns its data one clock edge after the request. A write to one bank's words leaves the words of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_rd | input | 1 | Read strobe; data appears after the next edge |
| bus_addr | input | ADDR_W (12) | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS*32 (96) | Asynchronous pin inputs |
| pin_out | output | NUM_BANKS*32 (96) | Output latch values |
| pin_oe | output | NUM_BANKS*32 (96) | Output enables (direction bits) |
| irq_any | output | 1 | Combined interrupt over all gated status bits |
| irq_pin0 | output | 1 | Dedicated interrupt of bank 0 pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt of bank 0 pin 1 |

## Verification
The bench times a clearing write so that it lands in the same cycle as a fresh rising edge on the same pin. A design that lets the clear win would drop that edge, and the status read afterwards would show 0. A second test raises a pin that has only falling capture enabled, and then drops it. A design that mixes up the two enables would flag the pin on the wrong transition. The bench also drives edges on pins whose gate bit is 0, and writes a partial mask to the clear word. These catch a design that ignores the gate, or that clears more bits than were written. It reads each bank's copy of a word after writing another bank's copy, which shows up any error in the interleaved address decode.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    // Pins per bank; bit (pin mod GPB_W) of each word belongs to the pin.
    localparam int GPB_W = 32;

    // Byte offsets of bank 0's copy; bank n adds 4*n.
    localparam int OFF_LEVEL = 'h00;
    localparam int OFF_DIR   = 'h0C;
    localparam int OFF_SET   = 'h18;
    localparam int OFF_CLR   = 'h24;
    localparam int OFF_RISE  = 'h30;
    localparam int OFF_FALL  = 'h3C;
    localparam int OFF_STAT  = 'h48;
    localparam int OFF_GATE  = 'h9C;

    // Per-bank architectural state.
    typedef struct packed {
        logic [GPB_W-1:0] dir;
        logic [GPB_W-1:0] outl;
        logic [GPB_W-1:0] rise;
        logic [GPB_W-1:0] fall;
        logic [GPB_W-1:0] stat;
        logic [GPB_W-1:0] gate;
        logic [GPB_W-1:0] prev;
    } bank_st_t;

    // Byte address of register 'off' in bank 'bank' (banks are interleaved
    // inside one 256-byte page for the three banks of the first group).
    function automatic int reg_addr(input int off, input int bank);
        return ((bank / 3) << 8) + ((bank % 3) << 2) + off;
    endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BANK_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [GPB_W-1:0]  wdata,
    input  logic [GPB_W-1:0]  pin_in,
    output logic [GPB_W-1:0]  rd_data,
    output logic [GPB_W-1:0]  pin_out,
    output logic [GPB_W-1:0]  pin_oe,
    output logic [GPB_W-1:0]  stat_act
);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(reg_addr(OFF_LEVEL, BANK_IDX));
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(reg_addr(OFF_DIR,   BANK_IDX));
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(reg_addr(OFF_SET,   BANK_IDX));
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(reg_addr(OFF_CLR,   BANK_IDX));
    localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(reg_addr(OFF_RISE,  BANK_IDX));
    localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(reg_addr(OFF_FALL,  BANK_IDX));
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(reg_addr(OFF_STAT,  BANK_IDX));
    localparam logic [ADDR_W-1:0] A_GATE  = ADDR_W'(reg_addr(OFF_GATE,  BANK_IDX));

    bank_st_t         st_d, st_q;
    logic [GPB_W-1:0] lvl;
    logic [GPB_W-1:0] edge_ev;
    logic [GPB_W-1:0] w1c;
    logic             hit_set, hit_clr;

    gpb_sync #(.W(GPB_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (lvl)
    );

    assign hit_set = wr_en && (addr == A_SET);
    assign hit_clr = wr_en && (addr == A_CLR);

    always_comb begin
        logic [GPB_W-1:0] rise_ev;
        logic [GPB_W-1:0] fall_ev;
        st_d      = st_q;
        st_d.prev = lvl;
        rise_ev   = lvl & ~st_q.prev;
        fall_ev   = ~lvl & st_q.prev;
        edge_ev   = ((rise_ev & st_q.rise) | (fall_ev & st_q.fall)) & st_q.gate;
        w1c       = (wr_en && (addr == A_STAT)) ? wdata : '0;
        // A new edge outranks a clear in the same cycle.
        st_d.stat = (st_q.stat & ~w1c) | edge_ev;
        if (wr_en) begin
            unique case (addr)
                A_DIR:   st_d.dir  = wdata;
                A_SET:   st_d.outl = st_q.outl | wdata;
                A_CLR:   st_d.outl = st_q.outl & ~wdata;
                A_RISE:  st_d.rise = wdata;
                A_FALL:  st_d.fall = wdata;
                A_GATE:  st_d.gate = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            A_LEVEL: rd_data = lvl;
            A_DIR:   rd_data = st_q.dir;
            A_RISE:  rd_data = st_q.rise;
            A_FALL:  rd_data = st_q.fall;
            A_STAT:  rd_data = st_q.stat;
            A_GATE:  rd_data = st_q.gate;
            default: rd_data = '0;
        endcase
    end

    assign pin_out  = st_q.outl;
    assign pin_oe   = st_q.dir;
    assign stat_act = st_q.stat & st_q.gate;

    // R2
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((st_q.outl & $past(wdata)) == $past(wdata)));

    // R3
    out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((st_q.outl & $past(wdata)) == '0));

    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.stat & ~w1c) != '0) |=>
        ((st_q.stat & $past(st_q.stat & ~w1c)) == $past(st_q.stat & ~w1c)));

    // R9
    stat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & ~$past(st_q.stat) & ~$past(st_q.gate)) == '0));

    // R11
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev != '0) |=> ((st_q.stat & $past(edge_ev)) == $past(edge_ev)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [GPB_W-1:0]           bus_wdata,
    output logic [GPB_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*GPB_W-1:0] pin_in,
    output logic [NUM_BANKS*GPB_W-1:0] pin_out,
    output logic [NUM_BANKS*GPB_W-1:0] pin_oe,
    output logic                       irq_any,
    output logic                       irq_pin0,
    output logic                       irq_pin1
);
    localparam int NPINS = NUM_BANKS * GPB_W;

    typedef struct packed {
        logic [GPB_W-1:0] rdata;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [GPB_W-1:0] rd_vec  [NUM_BANKS];
    logic [NPINS-1:0] act_all;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpb_bank #(.ADDR_W(ADDR_W), .BANK_IDX(b)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr),
            .addr    (bus_addr),
            .wdata   (bus_wdata),
            .pin_in  (pin_in [b*GPB_W +: GPB_W]),
            .rd_data (rd_vec[b]),
            .pin_out (pin_out[b*GPB_W +: GPB_W]),
            .pin_oe  (pin_oe [b*GPB_W +: GPB_W]),
            .stat_act(act_all[b*GPB_W +: GPB_W])
        );
    end

    always_comb begin
        logic [GPB_W-1:0] mux;
        mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) mux |= rd_vec[b];
        st_d = st_q;
        if (bus_rd) st_d.rdata = mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_any   = |act_all;
    assign irq_pin0  = act_all[0];
    assign irq_pin1  = act_all[1];

    // R10
    irq_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin0 || irq_pin1) |-> irq_any);

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    localparam int NB = 3;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [95:0]   pin_in = '0;
    logic [95:0]   pin_out, pin_oe;
    logic          irq_any, irq_pin0, irq_pin1;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_any(irq_any), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1)
    );

    function automatic logic [AW-1:0] ra(input int off, input int b);
        return AW'(((b / 3) << 8) + ((b % 3) << 2) + off);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected word; the monitor compares it.
    task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: read data is registered on the edge after the strobe.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R12: unexpected read data %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64], 32'h0);
        check("R1 pin_oe",  pin_oe[31:0]  | pin_oe[63:32]  | pin_oe[95:64], 32'h0);
        check("R1 irq", {29'h0, irq_any, irq_pin0, irq_pin1}, 32'h0);
        bus_read(ra('h0C, 0), 32'h0, "R1 dir");
        bus_read(ra('h9C, 2), 32'h0, "R1 gate");
        bus_read(ra('h48, 1), 32'h0, "R1 stat");
        bus_read(ra('h30, 0), 32'h0, "R1 rise");

        // R2 set word
        bus_write(ra('h18, 0), 32'h0000_00F0);
        check("R2 set", pin_out[31:0], 32'h0000_00F0);
        bus_write(ra('h18, 0), 32'h0000_000F);
        check("R2 set keep", pin_out[31:0], 32'h0000_00FF);
        bus_write(ra('h18, 0), 32'h0);
        check("R2 zero write", pin_out[31:0], 32'h0000_00FF);

        // R3 clear word
        bus_write(ra('h24, 0), 32'h0000_0030);
        check("R3 clear", pin_out[31:0], 32'h0000_00CF);
        check("R12 other bank out", pin_out[63:32], 32'h0);

        // R4 direction, R12 bank isolation
        bus_write(ra('h0C, 1), 32'h0000_A5A5);
        check("R4 oe", pin_oe[63:32], 32'h0000_A5A5);
        check("R12 bank0 oe", pin_oe[31:0], 32'h0);
        bus_read(ra('h0C, 1), 32'h0000_A5A5, "R4 readback");
        bus_read(ra('h0C, 2), 32'h0, "R12 bank2 dir");

        // R5 level
        @(negedge clk); pin_in[95:64] = 32'h1234_5678;
        settle();
        bus_read(ra('h00, 2), 32'h1234_5678, "R5 level");

        // R6 rising capture, R10 dedicated line
        bus_write(ra('h9C, 0), 32'hFFFF_FFFF);
        bus_write(ra('h30, 0), 32'h0000_0005);
        bus_write(ra('h3C, 0), 32'h0000_0002);
        @(negedge clk); pin_in[0] = 1'b1;
        settle();
        bus_read(ra('h48, 0), 32'h1, "R6 rise");
        check("R10 irq_pin0", {31'h0, irq_pin0}, 32'h1);
        check("R10 irq_any",  {31'h0, irq_any}, 32'h1);

        // R7 falling only
        @(negedge clk); pin_in[1] = 1'b1;
        settle();
        bus_read(ra('h48, 0), 32'h1, "R7 no rise flag");
        @(negedge clk); pin_in[1] = 1'b0;
        settle();
        bus_read(ra('h48, 0), 32'h3, "R7 fall");
        check("R10 irq_pin1", {31'h0, irq_pin1}, 32'h1);

        // R8 write-1-to-clear
        bus_write(ra('h48, 0), 32'h2);
        bus_read(ra('h48, 0), 32'h1, "R8 partial clear");
        check("R8 irq_pin1 low", {31'h0, irq_pin1}, 32'h0);
        bus_write(ra('h48, 0), 32'h1);
        check("R8 irq_any low", {31'h0, irq_any}, 32'h0);

        // R9 gate
        bus_write(ra('h30, 1), 32'h0000_00FF);
        bus_write(ra('h9C, 1), 32'h0000_000F);
        @(negedge clk); pin_in[39:32] = 8'hFF;
        settle();
        bus_read(ra('h48, 1), 32'h0000_000F, "R9 gated");
        check("R10 irq_any bank1", {31'h0, irq_any}, 32'h1);
        check("R10 pin0 unaffected", {31'h0, irq_pin0}, 32'h0);
        bus_write(ra('h48, 1), 32'hFFFF_FFFF);
        check("R8 full clear", {31'h0, irq_any}, 32'h0);

        // R11 edge and clear in the same cycle (pin2 rise enabled)
        @(negedge clk); pin_in[2] = 1'b1;
        settle();
        @(negedge clk); pin_in[2] = 1'b0;
        settle();
        bus_read(ra('h48, 0), 32'h4, "R11 setup");
        @(negedge clk); pin_in[2] = 1'b1;   // status sets on the 3rd edge
        @(negedge clk);
        bus_write(ra('h48, 0), 32'h4);      // lands on that same edge
        bus_read(ra('h48, 0), 32'h4, "R11 edge wins");
        bus_write(ra('h48, 0), 32'h4);
        bus_read(ra('h48, 0), 32'h0, "R11 plain clear");

        settle();
        check("R12 queue drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule